// File: doc/BRIEF.md
# System Register Access Trap Decoder

This block judges accesses to a bank of architected activity-counter system registers before any register is touched. It watches decoded instruction fields (op0, op1, CRn, CRm, op2), a read/write flag and the current privilege level. It also takes a set of trap and feature controls from the surrounding configuration state. It decides whether the access goes ahead, raises an undefined-instruction exception, or is routed as a trap to privilege level 1, 2 or 3.

A valid strobe with a matching encoding produces a registered verdict one clock later. The verdict has three flags (allow, undefined, trap), a 2-bit target level and a 6-bit syndrome class. Reads pass through a fixed priority chain that depends on the level. Writes are allowed only from the highest implemented level. Encodings that belong to other registers are not claimed, so no verdict appears for them.

Top module: `sysreg_trap_decoder`

## Requirements
- R1: An access is claimed only when op0=2'b11, op1=3'b011, CRn=4'b1101 and CRm[3:1]=3'b010. An unclaimed access, or a cycle without `req_valid`, produces no `res_valid`.
- R2: `res_valid` rises exactly one clock after a claimed `req_valid`. While `res_valid` is low, all three result flags are low.
- R3: Whenever `res_valid` is high, exactly one of `res_allow`, `res_undef` and `res_trap` is high. `res_target` is 0 and `res_ec` is 0 unless `res_trap` is high. A trap reports `res_ec` = 6'h18 and a target level of 1, 2 or 3.
- R4: The counter index is {CRm[0], op2[2:0]}. An index of NUM_CTR (4) or more gives undefined, for both reads and writes.
- R5: A read at level 0, 1 or 2 is undefined first of all when level 3 is present, `sdd_prio` is set and `el3_tam` is set.
- R6: Next, a level-0 read with `user_en` clear traps. It goes to level 2 when `el2_enabled` and `tge` are both set, and to level 1 otherwise.
- R7: Next, a level-0 or level-1 read with `el2_enabled` and `el2_tam` set traps to level 2.
- R8: Next, a level-0 or level-1 read traps to level 2 when all of the following hold: `el2_enabled` is set, `fgt_present` is set, `fgt_en` is set or level 3 is absent, and the indexed bit of `fgt_ctr` is set. At level 0 this also requires `host_mode` to be clear.
- R9: Last, a level-0 or level-1 read with level 3 present and `el3_tam` set is undefined if `sdd_undef` is set, and traps to level 3 otherwise. A read that reaches no rule is allowed.
- R10: At level 2, only the rules of R5 and R9 apply, in that order. Otherwise the read is allowed.
- R11: A read at level 3 with a valid index is always allowed.
- R12: A write with a valid index is allowed only when `cur_el` equals the highest level. The highest level is 3 if `el3_present` is set, else 2 if `el2_enabled` is set, else 1. Any other valid-index write is undefined. Levels are encoded 0 to 3 on `cur_el`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| is_write | input | 1 | 1 = write, 0 = read |
| cur_el | input | 2 | Current privilege level 0..3 |
| el3_present | input | 1 | Level 3 implemented |
| el2_enabled | input | 1 | Level 2 enabled in the current state |
| host_mode | input | 1 | Level 0 runs under a host-mode level 2 |
| tge | input | 1 | Route general level-0 exceptions to level 2 |
| user_en | input | 1 | Level-0 counter access enable |
| el2_tam | input | 1 | Level-2 activity-counter trap bit |
| el3_tam | input | 1 | Level-3 activity-counter trap bit |
| fgt_present | input | 1 | Fine-grained trap feature implemented |
| fgt_en | input | 1 | Level-3 enable of fine-grained traps |
| fgt_ctr | input | NUM_CTR | Per-counter fine-grained read trap bits |
| sdd_prio | input | 1 | Strict-undefined takes priority |
| sdd_undef | input | 1 | Strict-undefined active for level-3 traps |
| res_valid | output | 1 | Verdict valid |
| res_allow | output | 1 | Access allowed |
| res_undef | output | 1 | Access undefined |
| res_trap | output | 1 | Access traps |
| res_target | output | 2 | Trap target level |
| res_ec | output | 6 | Syndrome exception class |

## Verification
Every verdict is due in the first clock after the strobe that carried the access: one register stands between the inputs and all result outputs. The bench drives a new access on each falling edge. The rising edge in between latches it, and the bench compares the outputs at the next falling edge, before it changes the inputs again. So every compare sees the verdict of exactly one access. Reads are swept over all 4096 combinations of the twelve control bits, at every level and for several indices on both sides of the index limit. Writes and unclaimed encodings are swept separately.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;

  typedef enum logic [1:0] {
    VK_ALLOW = 2'd0,
    VK_UNDEF = 2'd1,
    VK_TRAP  = 2'd2
  } verdict_kind_e;

  typedef struct packed {
    verdict_kind_e kind;
    logic [1:0]    tgt;
  } verdict_t;

  localparam logic [5:0] SYNDROME_CLASS = 6'h18;
  localparam int unsigned IDX_W = 4;

  // Highest implemented privilege level from the presence controls.
  function automatic logic [1:0] top_level(input logic l3, input logic l2);
    if (l3)      return 2'd3;
    else if (l2) return 2'd2;
    else         return 2'd1;
  endfunction

  function automatic verdict_t mk_trap(input logic [1:0] lvl);
    verdict_t v;
    v.kind = VK_TRAP;
    v.tgt  = lvl;
    return v;
  endfunction

  function automatic verdict_t mk_plain(input verdict_kind_e k);
    verdict_t v;
    v.kind = k;
    v.tgt  = 2'd0;
    return v;
  endfunction

endpackage

// File: rtl/trap_enc_match.sv
module trap_enc_match
  import sysreg_trap_pkg::*;
#(
  parameter int unsigned NUM_CTR = 4
) (
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             idx_ok
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_CTR);

  assign hit    = (op0 == 2'b11) && (op1 == 3'b011) &&
                  (crn == 4'b1101) && (crm[3:1] == 3'b010);
  assign idx    = {crm[0], op2};
  assign idx_ok = ({1'b0, idx} < LIMIT);
endmodule

// File: rtl/trap_read_chain.sv
module trap_read_chain
  import sysreg_trap_pkg::*;
(
  input  logic [1:0] cur_el,
  input  logic       el3_present,
  input  logic       el2_enabled,
  input  logic       host_mode,
  input  logic       tge,
  input  logic       user_en,
  input  logic       el2_tam,
  input  logic       el3_tam,
  input  logic       fgt_present,
  input  logic       fgt_en,
  input  logic       fg_bit,
  input  logic       sdd_prio,
  input  logic       sdd_undef,
  output verdict_t   verdict,
  output logic       s_sdd_first,
  output logic       s_user_off,
  output logic       s_l2_tam,
  output logic       s_fg_lvl0,
  output logic       s_fg_lvl1,
  output logic       s_l3_tam
);
  logic fg_common;
  verdict_t l3_tail;

  assign s_sdd_first = el3_present & sdd_prio & el3_tam;
  assign s_user_off  = ~user_en;
  assign s_l2_tam    = el2_enabled & el2_tam;
  assign fg_common   = el2_enabled & fgt_present & (~el3_present | fgt_en) & fg_bit;
  assign s_fg_lvl0   = fg_common & ~host_mode;
  assign s_fg_lvl1   = fg_common;
  assign s_l3_tam    = el3_present & el3_tam;

  // Final level-3 step: undefined when strict-undefined is active.
  always_comb begin
    if (!s_l3_tam)      l3_tail = mk_plain(VK_ALLOW);
    else if (sdd_undef) l3_tail = mk_plain(VK_UNDEF);
    else                l3_tail = mk_trap(2'd3);
  end

  always_comb begin
    unique case (cur_el)
      2'd0: begin
        if (s_sdd_first)     verdict = mk_plain(VK_UNDEF);
        else if (s_user_off) verdict = mk_trap((el2_enabled & tge) ? 2'd2 : 2'd1);
        else if (s_l2_tam)   verdict = mk_trap(2'd2);
        else if (s_fg_lvl0)  verdict = mk_trap(2'd2);
        else                 verdict = l3_tail;
      end
      2'd1: begin
        if (s_sdd_first)     verdict = mk_plain(VK_UNDEF);
        else if (s_l2_tam)   verdict = mk_trap(2'd2);
        else if (s_fg_lvl1)  verdict = mk_trap(2'd2);
        else                 verdict = l3_tail;
      end
      2'd2: begin
        if (s_sdd_first)     verdict = mk_plain(VK_UNDEF);
        else                 verdict = l3_tail;
      end
      default:               verdict = mk_plain(VK_ALLOW);
    endcase
  end
endmodule

// File: rtl/trap_result_reg.sv
module trap_result_reg
  import sysreg_trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  verdict_t   verdict,
  output logic       res_valid,
  output logic       res_allow,
  output logic       res_undef,
  output logic       res_trap,
  output logic [1:0] res_target,
  output logic [5:0] res_ec
);
  logic is_trap;
  assign is_trap = (verdict.kind == VK_TRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_allow  <= 1'b0;
      res_undef  <= 1'b0;
      res_trap   <= 1'b0;
      res_target <= 2'd0;
      res_ec     <= 6'd0;
    end else begin
      res_valid  <= load;
      res_allow  <= load & (verdict.kind == VK_ALLOW);
      res_undef  <= load & (verdict.kind == VK_UNDEF);
      res_trap   <= load & is_trap;
      res_target <= (load & is_trap) ? verdict.tgt : 2'd0;
      res_ec     <= (load & is_trap) ? SYNDROME_CLASS : 6'd0;
    end
  end

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_allow && !res_undef && !res_trap));

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(load));
endmodule

// File: rtl/sysreg_trap_decoder.sv
module sysreg_trap_decoder
  import sysreg_trap_pkg::*;
#(
  parameter int unsigned NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         op0,
  input  logic [2:0]         op1,
  input  logic [3:0]         crn,
  input  logic [3:0]         crm,
  input  logic [2:0]         op2,
  input  logic               is_write,
  input  logic [1:0]         cur_el,
  input  logic               el3_present,
  input  logic               el2_enabled,
  input  logic               host_mode,
  input  logic               tge,
  input  logic               user_en,
  input  logic               el2_tam,
  input  logic               el3_tam,
  input  logic               fgt_present,
  input  logic               fgt_en,
  input  logic [NUM_CTR-1:0] fgt_ctr,
  input  logic               sdd_prio,
  input  logic               sdd_undef,
  output logic               res_valid,
  output logic               res_allow,
  output logic               res_undef,
  output logic               res_trap,
  output logic [1:0]         res_target,
  output logic [5:0]         res_ec
);
  localparam int unsigned SEL_W = 1 << IDX_W;

  logic             enc_hit;
  logic [IDX_W-1:0] enc_idx;
  logic             idx_ok;
  logic [SEL_W-1:0] fg_ext;
  logic             fg_bit;
  logic             wr_top;
  verdict_t         rd_verdict;
  verdict_t         final_verdict;
  logic             s_sdd_first, s_user_off, s_l2_tam, s_fg_lvl0, s_fg_lvl1, s_l3_tam;

  trap_enc_match #(.NUM_CTR(NUM_CTR)) match_i (
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .hit(enc_hit), .idx(enc_idx), .idx_ok(idx_ok)
  );

  assign fg_ext = SEL_W'(fgt_ctr);
  assign fg_bit = fg_ext[enc_idx];

  trap_read_chain chain_i (
    .cur_el(cur_el), .el3_present(el3_present), .el2_enabled(el2_enabled),
    .host_mode(host_mode), .tge(tge), .user_en(user_en),
    .el2_tam(el2_tam), .el3_tam(el3_tam), .fgt_present(fgt_present),
    .fgt_en(fgt_en), .fg_bit(fg_bit), .sdd_prio(sdd_prio), .sdd_undef(sdd_undef),
    .verdict(rd_verdict),
    .s_sdd_first(s_sdd_first), .s_user_off(s_user_off), .s_l2_tam(s_l2_tam),
    .s_fg_lvl0(s_fg_lvl0), .s_fg_lvl1(s_fg_lvl1), .s_l3_tam(s_l3_tam)
  );

  assign wr_top = (cur_el == top_level(el3_present, el2_enabled));

  always_comb begin
    if (!idx_ok)       final_verdict = mk_plain(VK_UNDEF);
    else if (is_write) final_verdict = mk_plain(wr_top ? VK_ALLOW : VK_UNDEF);
    else               final_verdict = rd_verdict;
  end

  trap_result_reg result_i (
    .clk(clk), .rst_n(rst_n), .load(req_valid & enc_hit), .verdict(final_verdict),
    .res_valid(res_valid), .res_allow(res_allow), .res_undef(res_undef),
    .res_trap(res_trap), .res_target(res_target), .res_ec(res_ec)
  );

  p_unclaimed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && (op0 != 2'b11 || crn != 4'b1101)) |-> !res_valid);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_allow, res_undef, res_trap}) == 1));

  p_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_trap |-> (res_ec == 6'h18 && res_target != 2'd0));

  p_bad_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(!idx_ok)) |-> res_undef);

  p_lvl2_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_trap && $past(cur_el == 2'd2 && !is_write)) |-> res_target == 2'd3);

  p_lvl3_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cur_el == 2'd3 && !is_write && idx_ok)) |-> res_allow);

  p_write_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(is_write && idx_ok)) |-> (res_allow == $past(wr_top)));

  p_user_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cur_el == 2'd0 && !is_write && idx_ok && s_user_off && !s_sdd_first))
      |-> (res_trap && res_target != 2'd3));
endmodule

// File: tb/sysreg_trap_decoder_tb_top.sv
module sysreg_trap_decoder_tb_top;
  localparam time TCLK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] op0 = 2'b11;
  logic [2:0] op1 = 3'b011;
  logic [3:0] crn = 4'b1101;
  logic [3:0] crm = 4'b0100;
  logic [2:0] op2 = 3'b000;
  logic is_write = 1'b0;
  logic [1:0] cur_el = 2'd0;
  logic el3_present = 0, el2_enabled = 0, host_mode = 0, tge = 0, user_en = 0;
  logic el2_tam = 0, el3_tam = 0, fgt_present = 0, fgt_en = 0;
  logic [3:0] fgt_ctr = 4'd0;
  logic sdd_prio = 0, sdd_undef = 0;
  logic res_valid, res_allow, res_undef, res_trap;
  logic [1:0] res_target;
  logic [5:0] res_ec;

  int n_checks = 0;
  int n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  sysreg_trap_decoder #(.NUM_CTR(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .is_write(is_write), .cur_el(cur_el),
    .el3_present(el3_present), .el2_enabled(el2_enabled), .host_mode(host_mode),
    .tge(tge), .user_en(user_en), .el2_tam(el2_tam), .el3_tam(el3_tam),
    .fgt_present(fgt_present), .fgt_en(fgt_en), .fgt_ctr(fgt_ctr),
    .sdd_prio(sdd_prio), .sdd_undef(sdd_undef),
    .res_valid(res_valid), .res_allow(res_allow), .res_undef(res_undef),
    .res_trap(res_trap), .res_target(res_target), .res_ec(res_ec)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected verdict as code: 0 allow, 1 undef, 4+target = trap.
  function automatic int expect_code(input int el, input int idx, input bit wr,
                                     input int k, output string tag);
    bit e3 = k[0], e2 = k[1], hst = k[2], tg = k[3], ue = k[4], t2 = k[5];
    bit t3 = k[6], fp = k[7], fe = k[8], fb = k[9], sp = k[10], su = k[11];
    int hi = e3 ? 3 : (e2 ? 2 : 1);
    bit fg_gate = e2 && fp && (fe || !e3) && fb;
    if (idx >= 4) begin tag = "R4"; return 1; end
    if (wr) begin tag = "R12"; return (el == hi) ? 0 : 1; end
    if (el == 3) begin tag = "R11"; return 0; end
    if (el == 2) begin
      tag = "R10";
      if (e3 && sp && t3) return 1;
      if (e3 && t3) return su ? 1 : 7;
      return 0;
    end
    if (e3 && sp && t3) begin tag = "R5"; return 1; end
    if (el == 0 && !ue) begin tag = "R6"; return (e2 && tg) ? 6 : 5; end
    if (e2 && t2) begin tag = "R7"; return 6; end
    if (fg_gate && (el == 1 || !hst)) begin tag = "R8"; return 6; end
    tag = "R9";
    if (e3 && t3) return su ? 1 : 7;
    return 0;
  endfunction

  task automatic apply_and_check(input int el, input int idx, input bit wr, input int k);
    string tag;
    int exp_code, act_code;
    cur_el = 2'(el); is_write = wr;
    crm = {3'b010, 1'(idx >> 3)}; op2 = 3'(idx);
    el3_present = k[0]; el2_enabled = k[1]; host_mode = k[2]; tge = k[3];
    user_en = k[4]; el2_tam = k[5]; el3_tam = k[6]; fgt_present = k[7];
    fgt_en = k[8]; sdd_prio = k[10]; sdd_undef = k[11];
    if (idx < 4) fgt_ctr = k[9] ? (4'd1 << idx) : ~(4'd1 << idx);
    else         fgt_ctr = {4{k[9]}};
    req_valid = 1'b1;
    exp_code = expect_code(el, idx, wr, k, tag);
    @(negedge clk);
    act_code = res_trap ? (4 + res_target) : (res_undef ? 1 : 0);
    if (!res_valid || (res_allow + res_undef + res_trap) != 1) act_code = 99;
    check(tag, act_code, exp_code);
    // R3: class and target reported only for traps
    check("R3", {res_ec, res_target}, res_trap ? {6'h18, res_target} : 0);
  endtask

  task automatic probe_unclaimed(input logic [1:0] a, input logic [2:0] b,
                                 input logic [3:0] c, input logic [3:0] d, input logic v);
    op0 = a; op1 = b; crn = c; crm = d; op2 = 3'd0; req_valid = v;
    @(negedge clk);
    check(v ? "R1" : "R2", {res_valid, res_allow, res_undef, res_trap}, 0);
  endtask

  initial begin
    #(TCLK * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", {res_valid, res_allow, res_undef, res_trap, res_target, res_ec}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", res_valid, 0);

    // R1: non-matching encodings and an idle strobe
    probe_unclaimed(2'b10, 3'b011, 4'b1101, 4'b0100, 1'b1);
    probe_unclaimed(2'b11, 3'b010, 4'b1101, 4'b0100, 1'b1);
    probe_unclaimed(2'b11, 3'b011, 4'b1100, 4'b0100, 1'b1);
    probe_unclaimed(2'b11, 3'b011, 4'b1101, 4'b0110, 1'b1);
    probe_unclaimed(2'b11, 3'b011, 4'b1101, 4'b0000, 1'b1);
    probe_unclaimed(2'b11, 3'b011, 4'b1101, 4'b0100, 1'b0);
    op0 = 2'b11; op1 = 3'b011; crn = 4'b1101;

    // Reads: every control combination at every level
    for (int el = 0; el < 4; el++)
      for (int s = 0; s < 4; s++) begin
        int idx = (s == 0) ? 0 : (s == 1) ? 3 : (s == 2) ? 6 : 9;
        for (int k = 0; k < 4096; k++) apply_and_check(el, idx, 1'b0, k);
      end

    // Writes: level vs highest level, and index limit
    for (int el = 0; el < 4; el++)
      for (int p = 0; p < 4; p++)
        for (int idx = 0; idx < 13; idx++)
          apply_and_check(el, idx, 1'b1, p | 16);

    req_valid = 1'b0;
    @(negedge clk);
    check("R2", res_valid, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule